// File: doc/BRIEF.md
# Serial Flash Status Register Target

This block is a SPI mode-0 target that models only the status-register side of a serial NOR flash. After chip-select falls, the first eight bits clocked in form an opcode. The target then does one of four things: reads status byte 1, reads status byte 2, sets the write-enable latch, or takes a status write of one or two data bytes. The quad-enable bit and the block-protect field are driven as outputs, so that surrounding logic can follow the protection and lane-mode state that the host software programs.

The SPI pins are sampled by a fast system clock through synchronizers. New status values are committed when chip-select is released, and only after a whole number of bytes. Two configuration inputs pick variants of the device. The first makes the status-byte-2 read opcode unsupported. The second selects a faulty device that wipes status byte 2 when a status write carries only one data byte. Host software must then always send two bytes to keep quad enable set.

Top module: `sfs_status_target`

## Requirements
- R1: After synchronous reset, status bytes 1 and 2 and the write-enable latch are zero, so `quad_en`, `block_prot` and `miso` are all low.
- R2: Opcode 0x05 returns status byte 1 MSB first, shifted out on falling SCLK. The byte repeats for as long as clocks continue. `miso` is low while chip-select is high.
- R3: Opcode 0x35 returns status byte 2 the same way. When `sr2_rd_off` is high this opcode is ignored and `miso` stays low.
- R4: Opcode 0x06 sets the write-enable latch, which reads back as bit 1 of status byte 1 (value 0x02 with the other bits clear).
- R5: A status write (opcode 0x01) when the write-enable latch is clear changes neither status byte.
- R6: A status write with one data byte loads status byte 1, clears the write-enable latch and, on a compliant device (`one_byte_clears_sr2` low), leaves status byte 2 unchanged.
- R7: A status write with two data bytes loads byte 1 into status byte 1 and byte 2 into status byte 2. `quad_en` follows bit 1 of status byte 2. `block_prot` follows bits 4:2 of status byte 1.
- R8: With `one_byte_clears_sr2` high, a one-byte status write clears status byte 2 to zero and drops `quad_en`. A two-byte write behaves as in R7.
- R9: If chip-select rises part way through a byte, nothing is committed and the write-enable latch keeps its value.
- R10: Bits 1:0 of status byte 1 (write-enable latch and busy) are not changed by the data of a status write.
- R11: Data bytes after the second in a status write are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that oversamples the SPI pins |
| rst | input | 1 | Synchronous active-high reset |
| sclk | input | 1 | SPI serial clock (mode 0) |
| cs_n | input | 1 | SPI chip-select, active low |
| mosi | input | 1 | Serial data from host |
| miso | output | 1 | Serial data to host, registered |
| sr2_rd_off | input | 1 | Makes the status-byte-2 read opcode unsupported |
| one_byte_clears_sr2 | input | 1 | Selects the faulty device that clears status byte 2 on a one-byte status write |
| quad_en | output | 1 | Quad-enable bit (status byte 2, bit 1) |
| block_prot | output | BP_W | Block-protect field (status byte 1, bits 4:2) |

## Verification
The bench goes after the rules that decide whether a write commits. It sends a status write with no write-enable, and a frame cut three bits into a byte. A design that commits on byte arrival, or that ignores the latch, would change the protect bits in these cases. It checks that a one-byte write leaves quad enable alone on the compliant variant and clears it on the faulty one; swapping or merging the two variants shows up as a wrong quad-enable level. It also reads a status byte twice in one frame, reads with the byte-2 opcode disabled, and writes 0xFF to status byte 1. These cases catch a shifter that does not reload, an opcode that still answers when disabled, and a write that reaches the latch or busy bit.

// File: rtl/sfs_pkg.sv
package sfs_pkg;
  localparam logic [7:0] OP_RD_S1 = 8'h05;
  localparam logic [7:0] OP_RD_S2 = 8'h35;
  localparam logic [7:0] OP_WR_S  = 8'h01;
  localparam logic [7:0] OP_WEN   = 8'h06;

  typedef enum logic [2:0] {
    XM_NONE,
    XM_RD1,
    XM_RD2,
    XM_WRS,
    XM_WEN
  } xfer_mode_e;
endpackage

// File: rtl/sfs_sync.sv
module sfs_sync #(
  parameter int W = 3,
  parameter int STAGES = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] pipe [STAGES];

  genvar s;
  generate
    for (s = 0; s < STAGES; s++) begin : g_stage
      always_ff @(posedge clk) begin
        if (rst) pipe[s] <= RST_VAL;
        else if (s == 0) pipe[s] <= d;
        else pipe[s] <= pipe[(s == 0) ? 0 : s-1];
      end
    end
  endgenerate

  assign q = pipe[STAGES-1];
endmodule

// File: rtl/sfs_frame.sv
module sfs_frame
  import sfs_pkg::*;
#(
  parameter int BYTE_W = 8,
  localparam int BIT_CW = $clog2(BYTE_W)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cs_idle,
  input  logic              sclk_rise,
  input  logic              mosi_s,
  input  logic              sr2_rd_off,
  output xfer_mode_e        mode,
  output logic [BIT_CW-1:0] bit_cnt,
  output logic [1:0]        byte_cnt,
  output logic [BYTE_W-1:0] data1,
  output logic [BYTE_W-1:0] data2
);
  logic [BYTE_W-1:0] rx_q;
  logic [BYTE_W-1:0] rx_next;
  logic              byte_end;
  xfer_mode_e        dec_mode;

  always_comb begin
    rx_next  = {rx_q[BYTE_W-2:0], mosi_s};
    byte_end = (bit_cnt == BIT_CW'(BYTE_W-1));
    case (rx_next)
      OP_RD_S1: dec_mode = XM_RD1;
      OP_RD_S2: dec_mode = sr2_rd_off ? XM_NONE : XM_RD2;
      OP_WR_S:  dec_mode = XM_WRS;
      OP_WEN:   dec_mode = XM_WEN;
      default:  dec_mode = XM_NONE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst || cs_idle) begin
      rx_q     <= '0;
      bit_cnt  <= '0;
      byte_cnt <= '0;
      mode     <= XM_NONE;
      data1    <= '0;
      data2    <= '0;
    end else if (sclk_rise) begin
      rx_q    <= rx_next;
      bit_cnt <= byte_end ? '0 : bit_cnt + 1'b1;
      if (byte_end) begin
        if (byte_cnt == 2'd0) mode <= dec_mode;
        if (byte_cnt == 2'd1) data1 <= rx_next;
        if (byte_cnt == 2'd2) data2 <= rx_next;
        if (byte_cnt != 2'd3) byte_cnt <= byte_cnt + 2'd1;
      end
    end
  end
endmodule

// File: rtl/sfs_regs.sv
module sfs_regs
  import sfs_pkg::*;
#(
  parameter int BYTE_W = 8,
  parameter int BP_W = 3,
  parameter int BP_LSB = 2,
  parameter int QE_BIT = 1,
  parameter int WEL_BIT = 1,
  parameter logic [BYTE_W-1:0] S1_WR_MASK = 8'hFC,
  localparam int BIT_CW = $clog2(BYTE_W)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cs_rise,
  input  xfer_mode_e        mode,
  input  logic [BIT_CW-1:0] bit_cnt,
  input  logic [1:0]        byte_cnt,
  input  logic [BYTE_W-1:0] data1,
  input  logic [BYTE_W-1:0] data2,
  input  logic              one_byte_clears_sr2,
  output logic [BYTE_W-1:0] stat1,
  output logic [BYTE_W-1:0] stat2,
  output logic              wel,
  output logic              commit,
  output logic              quad_en,
  output logic [BP_W-1:0]   block_prot
);
  logic [BYTE_W-1:0] s1_q;
  logic [BYTE_W-1:0] s2_q;
  logic              whole;
  logic              set_wel;
  logic              two_bytes;

  always_comb begin
    whole     = (bit_cnt == '0);
    set_wel   = cs_rise && whole && (mode == XM_WEN);
    commit    = cs_rise && whole && wel && (mode == XM_WRS) && (byte_cnt >= 2'd2);
    two_bytes = (byte_cnt == 2'd3);
    // busy bit is never set by this model, so it reads as zero
    stat1 = (s1_q & S1_WR_MASK) | (BYTE_W'(wel) << WEL_BIT);
    stat2 = s2_q;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      s1_q <= '0;
      s2_q <= '0;
      wel  <= 1'b0;
    end else if (commit) begin
      s1_q <= data1 & S1_WR_MASK;
      wel  <= 1'b0;
      if (two_bytes) s2_q <= data2;
      else if (one_byte_clears_sr2) s2_q <= '0;
    end else if (set_wel) begin
      wel <= 1'b1;
    end
  end

  assign quad_en    = s2_q[QE_BIT];
  assign block_prot = s1_q[BP_LSB +: BP_W];
endmodule

// File: rtl/sfs_tx.sv
module sfs_tx
  import sfs_pkg::*;
#(
  parameter int BYTE_W = 8,
  localparam int BIT_CW = $clog2(BYTE_W)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cs_idle,
  input  logic              sclk_fall,
  input  xfer_mode_e        mode,
  input  logic [BIT_CW-1:0] bit_cnt,
  input  logic [BYTE_W-1:0] stat1,
  input  logic [BYTE_W-1:0] stat2,
  output logic              miso
);
  logic [BYTE_W-1:0] sh_q;
  logic [BYTE_W-1:0] src;
  logic              reading;

  always_comb begin
    reading = (mode == XM_RD1) || (mode == XM_RD2);
    src     = (mode == XM_RD2) ? stat2 : stat1;
  end

  always_ff @(posedge clk) begin
    if (rst || cs_idle) begin
      sh_q <= '0;
      miso <= 1'b0;
    end else if (sclk_fall) begin
      if (!reading) begin
        sh_q <= '0;
        miso <= 1'b0;
      end else if (bit_cnt == '0) begin
        miso <= src[BYTE_W-1];
        sh_q <= {src[BYTE_W-2:0], 1'b0};
      end else begin
        miso <= sh_q[BYTE_W-1];
        sh_q <= {sh_q[BYTE_W-2:0], 1'b0};
      end
    end
  end
endmodule

// File: rtl/sfs_status_target.sv
module sfs_status_target
  import sfs_pkg::*;
#(
  parameter int BYTE_W = 8,
  parameter int SYNC_STAGES = 2,
  parameter int BP_W = 3,
  localparam int BIT_CW = $clog2(BYTE_W)
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            sclk,
  input  logic            cs_n,
  input  logic            mosi,
  output logic            miso,
  input  logic            sr2_rd_off,
  input  logic            one_byte_clears_sr2,
  output logic            quad_en,
  output logic [BP_W-1:0] block_prot
);
  logic [2:0]        pins_s;
  logic              sclk_s, cs_idle, mosi_s;
  logic              sclk_d, cs_d;
  logic              sclk_rise, sclk_fall, cs_rise;
  xfer_mode_e        mode;
  logic [BIT_CW-1:0] bit_cnt;
  logic [1:0]        byte_cnt;
  logic [BYTE_W-1:0] data1, data2, stat1, stat2;
  logic              wel, commit;

  sfs_sync #(.W(3), .STAGES(SYNC_STAGES), .RST_VAL(3'b010)) i_sync (
    .clk(clk), .rst(rst), .d({sclk, cs_n, mosi}), .q(pins_s)
  );

  assign {sclk_s, cs_idle, mosi_s} = pins_s;

  always_ff @(posedge clk) begin
    if (rst) begin
      sclk_d <= 1'b0;
      cs_d   <= 1'b1;
    end else begin
      sclk_d <= sclk_s;
      cs_d   <= cs_idle;
    end
  end

  assign sclk_rise = sclk_s && !sclk_d && !cs_idle;
  assign sclk_fall = !sclk_s && sclk_d && !cs_idle;
  assign cs_rise   = cs_idle && !cs_d;

  sfs_frame #(.BYTE_W(BYTE_W)) i_frame (
    .clk(clk), .rst(rst), .cs_idle(cs_idle), .sclk_rise(sclk_rise),
    .mosi_s(mosi_s), .sr2_rd_off(sr2_rd_off), .mode(mode),
    .bit_cnt(bit_cnt), .byte_cnt(byte_cnt), .data1(data1), .data2(data2)
  );

  sfs_regs #(.BYTE_W(BYTE_W), .BP_W(BP_W)) i_regs (
    .clk(clk), .rst(rst), .cs_rise(cs_rise), .mode(mode),
    .bit_cnt(bit_cnt), .byte_cnt(byte_cnt), .data1(data1), .data2(data2),
    .one_byte_clears_sr2(one_byte_clears_sr2), .stat1(stat1), .stat2(stat2),
    .wel(wel), .commit(commit), .quad_en(quad_en), .block_prot(block_prot)
  );

  sfs_tx #(.BYTE_W(BYTE_W)) i_tx (
    .clk(clk), .rst(rst), .cs_idle(cs_idle), .sclk_fall(sclk_fall),
    .mode(mode), .bit_cnt(bit_cnt), .stat1(stat1), .stat2(stat2),
    .miso(miso)
  );
endmodule

// File: rtl/sfs_status_checker.sv
module sfs_status_checker #(
  parameter int BP_W = 3,
  parameter int BIT_CW = 3
) (
  input logic              clk,
  input logic              rst,
  input logic              miso,
  input logic              quad_en,
  input logic [BP_W-1:0]   block_prot,
  input logic              cs_idle,
  input logic              cs_rise,
  input logic [BIT_CW-1:0] bit_cnt,
  input logic              wel,
  input logic              commit
);
  // R1: reset clears every visible state bit
  a_r1_reset_clear: assert property (@(posedge clk)
    rst |=> (!quad_en && block_prot == '0 && !miso && !wel));

  // R2: no data driven while deselected
  a_r2_idle_miso: assert property (@(posedge clk) disable iff (rst)
    cs_idle |=> !miso);

  // R4 / R6: a committed status write drops the latch
  a_r6_wel_drops: assert property (@(posedge clk) disable iff (rst)
    commit |=> !wel);

  // R5: protect or quad-enable changes need the latch set beforehand
  a_r5_needs_wel: assert property (@(posedge clk) disable iff (rst)
    (!$stable(quad_en) || !$stable(block_prot)) |-> $past(wel));

  // R9: a release in mid-byte changes nothing
  a_r9_partial_hold: assert property (@(posedge clk) disable iff (rst)
    (cs_rise && bit_cnt != '0) |=> ($stable(wel) && $stable(quad_en) && $stable(block_prot)));
endmodule

bind sfs_status_target sfs_status_checker #(.BP_W(BP_W), .BIT_CW(BIT_CW)) i_chk (
  .clk(clk), .rst(rst), .miso(miso), .quad_en(quad_en),
  .block_prot(block_prot), .cs_idle(cs_idle), .cs_rise(cs_rise),
  .bit_cnt(bit_cnt), .wel(wel), .commit(commit)
);

// File: tb/test_sfs_status_target.sv
`timescale 1ns/1ps
module test_sfs_status_target;
  localparam int H = 8;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       sclk = 1'b0;
  logic       cs_n = 1'b1;
  logic       mosi = 1'b0;
  logic       sr2_rd_off = 1'b0;
  logic       one_byte_clears_sr2 = 1'b0;
  logic       miso;
  logic       quad_en;
  logic [2:0] block_prot;

  int checks = 0;
  int errors = 0;
  logic [7:0] tx_b [4];
  logic [7:0] rx_b [4];

  always #4 clk = ~clk;

  sfs_status_target i_sfs_status_target (
    .clk(clk), .rst(rst), .sclk(sclk), .cs_n(cs_n), .mosi(mosi), .miso(miso),
    .sr2_rd_off(sr2_rd_off), .one_byte_clears_sr2(one_byte_clears_sr2),
    .quad_en(quad_en), .block_prot(block_prot)
  );

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
    end
  endtask

  task automatic send_bit(input logic b, output logic r);
    mosi = b;
    repeat (H) @(negedge clk);
    r = miso;
    sclk = 1'b1;
    repeat (H) @(negedge clk);
    sclk = 1'b0;
  endtask

  task automatic frame(input int nbytes, input int extra_bits);
    logic r;
    cs_n = 1'b0;
    repeat (H) @(negedge clk);
    for (int i = 0; i < nbytes; i++) begin
      for (int k = 7; k >= 0; k--) begin
        send_bit(tx_b[i][k], r);
        rx_b[i][k] = r;
      end
    end
    for (int e = 0; e < extra_bits; e++) send_bit(1'b0, r);
    repeat (H) @(negedge clk);
    cs_n = 1'b1;
    repeat (4*H) @(negedge clk);
  endtask

  task automatic wren();
    tx_b[0] = 8'h06;
    frame(1, 0);
  endtask

  task automatic rd(input logic [7:0] op, output logic [7:0] v);
    tx_b[0] = op; tx_b[1] = 8'h00;
    frame(2, 0);
    v = rx_b[1];
  endtask

  task automatic t_reset();
    logic [7:0] v;
    chk("R1 quad_en", {7'b0, quad_en}, 8'h00);
    chk("R1 block_prot", {5'b0, block_prot}, 8'h00);
    chk("R1 miso", {7'b0, miso}, 8'h00);
    rd(8'h05, v);
    chk("R1 status1", v, 8'h00);
  endtask

  task automatic t_no_wel();
    logic [7:0] v;
    tx_b[0] = 8'h01; tx_b[1] = 8'hFF; tx_b[2] = 8'hFF;
    frame(3, 0);
    rd(8'h05, v);
    chk("R5 status1 unchanged", v, 8'h00);
    chk("R5 quad_en unchanged", {7'b0, quad_en}, 8'h00);
  endtask

  task automatic t_wel_and_two_byte();
    logic [7:0] v;
    wren();
    rd(8'h05, v);
    chk("R4 latch readback", v, 8'h02);
    tx_b[0] = 8'h01; tx_b[1] = 8'hFF; tx_b[2] = 8'h02;
    frame(3, 0);
    chk("R7 quad_en", {7'b0, quad_en}, 8'h01);
    chk("R7 block_prot", {5'b0, block_prot}, 8'h07);
    tx_b[0] = 8'h05; tx_b[1] = 8'h00; tx_b[2] = 8'h00;
    frame(3, 0);
    chk("R2 first byte", rx_b[1], 8'hFC);
    chk("R2 repeated byte", rx_b[2], 8'hFC);
    chk("R10 low bits", rx_b[1] & 8'h03, 8'h00);
    chk("R2 miso idle", {7'b0, miso}, 8'h00);
    rd(8'h35, v);
    chk("R3 status2 read", v, 8'h02);
  endtask

  task automatic t_one_byte_ok();
    logic [7:0] v;
    wren();
    tx_b[0] = 8'h01; tx_b[1] = 8'h84;
    frame(2, 0);
    rd(8'h05, v);
    chk("R6 status1", v, 8'h84);
    chk("R6 quad_en kept", {7'b0, quad_en}, 8'h01);
    chk("R7 block_prot one-byte", {5'b0, block_prot}, 8'h01);
  endtask

  task automatic t_partial();
    logic [7:0] v;
    wren();
    tx_b[0] = 8'h01; tx_b[1] = 8'h00;
    frame(2, 3);
    rd(8'h05, v);
    chk("R9 no commit, latch kept", v, 8'h86);
    tx_b[0] = 8'h01; tx_b[1] = 8'h10;
    frame(2, 0);
    chk("R9 later write commits", {5'b0, block_prot}, 8'h04);
  endtask

  task automatic t_sr2_off();
    logic [7:0] v;
    sr2_rd_off = 1'b1;
    rd(8'h35, v);
    chk("R3 unsupported read low", v, 8'h00);
    sr2_rd_off = 1'b0;
    chk("R3 quad_en intact", {7'b0, quad_en}, 8'h01);
  endtask

  task automatic t_faulty();
    logic [7:0] v;
    one_byte_clears_sr2 = 1'b1;
    wren();
    tx_b[0] = 8'h01; tx_b[1] = 8'h20;
    frame(2, 0);
    chk("R8 quad_en cleared", {7'b0, quad_en}, 8'h00);
    rd(8'h35, v);
    chk("R8 status2 zero", v, 8'h00);
    wren();
    tx_b[0] = 8'h01; tx_b[1] = 8'h20; tx_b[2] = 8'h02;
    frame(3, 0);
    chk("R8 two-byte restores", {7'b0, quad_en}, 8'h01);
    one_byte_clears_sr2 = 1'b0;
  endtask

  task automatic t_extra();
    logic [7:0] v;
    wren();
    tx_b[0] = 8'h01; tx_b[1] = 8'h08; tx_b[2] = 8'h00; tx_b[3] = 8'hFF;
    frame(4, 0);
    rd(8'h35, v);
    chk("R11 status2 from second byte", v, 8'h00);
    rd(8'h05, v);
    chk("R11 status1", v, 8'h08);
  endtask

  initial begin
    int cyc = 0;
    forever begin
      @(posedge clk);
      cyc++;
      if (cyc > 150000) begin
        errors++;
        checks++;
        $display("FAIL watchdog actual=timeout expected=done");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
      end
    end
  end

  initial begin
    repeat (5) @(negedge clk);
    rst = 1'b0;
    repeat (5) @(negedge clk);
    t_reset();
    t_no_wel();
    t_wel_and_two_byte();
    t_one_byte_ok();
    t_partial();
    t_sr2_off();
    t_faulty();
    t_extra();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule